// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block maps a 24-bit virtual address onto a 32-bit physical address. It does this by fetching one 4-byte descriptor from a flat, in-memory page table. The descriptor supplies the frame number. The low 13 bits of the address are the byte offset within an 8 KB page, and they pass through unchanged. Three configuration registers control the translation:

- a table origin, which is the byte address of descriptor 0;
- a table size, which is the count of descriptors the table holds;
- a translation-enable bit.

When translation is disabled, the virtual address passes straight through to the physical side.

Each request is handled in one of two ways:

- The request ends in a fault code. The table-size check, the descriptor's present flag and its write-permission flag can each cause a fault.
- The request ends in a translated address. The block then keeps the descriptor's usage flags up to date. It sets the accessed flag on every successful lookup and the modified flag on every successful write. It writes the descriptor back to the table only when one of these flags actually changes.

The block serves one request at a time. It issues a single-word read to a simple memory port that has no stall input. Read data may return any number of cycles after the read is issued.

Top module: `pt_xlate`

## Requirements
- R1: The virtual address is split as follows: bits 12..0 are the byte offset and bits 23..13 are an 11-bit page index. A successful translation returns bits 31..13 of the descriptor as physical bits 31..13, with the offset copied into physical bits 12..0.
- R2: With translation enabled and the page index inside the table, the block issues exactly one read, at the address origin + 4 × page index.
- R3: Descriptor layout: bits 31..13 hold the frame number, bit 12 the modified flag, bit 11 the accessed flag, bit 10 the write-permission flag and bit 9 the present flag. Bits 8..0 are carried unchanged through any write-back.
- R4: A page index greater than or equal to the table-size register gives fault code 1. No memory access is made.
- R5: With translation disabled, the response carries the zero-extended virtual address and fault code 0. No memory access is made.
- R6: A descriptor with the present flag clear gives fault code 2. No write-back is made.
- R7: A write through a present descriptor whose write-permission flag is clear gives fault code 3. No write-back is made.
- R8: Every faulting response carries a physical address of zero.
- R9: A successful lookup writes the descriptor back with the accessed flag set, and also with the modified flag set when the access is a write. The write-back happens before the response, and only when the descriptor value changes.
- R10: The accept signal is high only while the block is idle and stays low until the response has been given. The response-valid signal is a single-cycle pulse.
- R11: A configuration load applies to every request accepted in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Loads the three configuration values below |
| cfg_base | input | 32 | Table origin byte address |
| cfg_len | input | 12 | Number of descriptors in the table (0 to 2048) |
| cfg_page_en | input | 1 | 1 = translate, 0 = pass through |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken when both are high |
| req_vaddr | input | 24 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address (zero on a fault) |
| rsp_fault | output | 2 | 0 none, 1 beyond table, 2 not present, 3 write-protected |
| mem_req | output | 1 | Memory access strobe, accepted in the same cycle |
| mem_we | output | 1 | 1 = descriptor write-back, 0 = descriptor read |
| mem_addr | output | 32 | Descriptor byte address |
| mem_wdata | output | 32 | Updated descriptor |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench targets the table-size boundary: the last index inside the table, the first index outside it, and a full 2048-entry table. A design with an off-by-one in the size check would either fault on a legal page or read beyond the end of the table.

It also covers the four combinations of the accessed and modified flags. A design that always writes back would show an extra memory write. One that forgets the modified flag would leave a stale descriptor in the modelled memory.

The bench checks that faulting and pass-through requests make no memory access, and that faults carry a zero address. It also reloads the configuration between requests to catch a design that latches it too early or too late. Random read latencies test the wait for read data.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_RANGE  = 2'd1,
      FLT_ABSENT = 2'd2,
      FLT_RDONLY = 2'd3
   } flt_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_WAIT  = 3'd2,
      ST_WBACK = 3'd3,
      ST_RESP  = 3'd4
   } st_e;

endpackage

// File: rtl/pt_index_gen.sv
module pt_index_gen #(
   parameter int PA_W   = 32,
   parameter int PN_W   = 11,
   parameter int ENT_SH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PN_W-1:0]   page_in,
   input  logic [PA_W-1:0]   tbl_base,
   input  logic [PN_W:0]     tbl_len,
   output logic [PA_W-1:0]   ent_addr,
   output logic              beyond
);
   localparam int PAD_W = PA_W - PN_W - ENT_SH;

   logic [PA_W-1:0] idx_bytes;

   assign idx_bytes = {{PAD_W{1'b0}}, page_in, {ENT_SH{1'b0}}};
   assign ent_addr  = tbl_base + idx_bytes;
   assign beyond    = ({1'b0, page_in} >= tbl_len);

   // R2: any address inside the bound lies inside the table span
   assert_entry_in_table_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !beyond |-> ({1'b0, ent_addr - tbl_base} <
                   {{PAD_W{1'b0}}, tbl_len, {ENT_SH{1'b0}}}));

   // R4: an empty table rejects every page
   assert_empty_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_len == '0) |-> beyond);

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
   import pt_xlate_pkg::*;
#(
   parameter int PA_W  = 32,
   parameter int OFS_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic [PA_W-1:0]   pte_in,
   input  logic              is_write,
   output flt_e              fault,
   output logic [PA_W-OFS_W-1:0] frame,
   output logic [PA_W-1:0]   pte_out,
   output logic              need_wb
);
   localparam int BIT_D = OFS_W - 1;
   localparam int BIT_R = OFS_W - 2;
   localparam int BIT_W = OFS_W - 3;
   localparam int BIT_V = OFS_W - 4;

   logic [PA_W-1:0] set_mask;

   assign frame = pte_in[PA_W-1:OFS_W];

   always_comb begin
      set_mask        = '0;
      set_mask[BIT_R] = 1'b1;
      set_mask[BIT_D] = is_write;
   end

   always_comb begin
      if (!pte_in[BIT_V])
         fault = FLT_ABSENT;
      else if (is_write && !pte_in[BIT_W])
         fault = FLT_RDONLY;
      else
         fault = FLT_NONE;
   end

   assign pte_out = pte_in | set_mask;
   assign need_wb = (fault == FLT_NONE) && (pte_out != pte_in);

   // R6 R7: a faulting descriptor is never written back
   assert_fault_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en && (fault != FLT_NONE) |-> !need_wb);

   // R9: write-back keeps the frame and the spare bits, and marks the entry accessed
   assert_wb_keeps_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en && need_wb |-> (pte_out[PA_W-1:OFS_W] == pte_in[PA_W-1:OFS_W]) &&
                            (pte_out[BIT_V-1:0] == pte_in[BIT_V-1:0]) && pte_out[BIT_R]);

   // R7: write through a non-writable present entry
   assert_rdonly_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en && is_write && pte_in[BIT_V] && !pte_in[BIT_W] |-> fault == FLT_RDONLY);

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
   import pt_xlate_pkg::*;
#(
   parameter int VA_W   = 24,
   parameter int PA_W   = 32,
   parameter int OFS_W  = 13,
   parameter int ENT_SH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [PA_W-1:0]   cfg_base,
   input  logic [VA_W-OFS_W:0] cfg_len,
   input  logic              cfg_page_en,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic              req_write,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic [1:0]        rsp_fault,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PA_W-1:0]   mem_addr,
   output logic [PA_W-1:0]   mem_wdata,
   input  logic              mem_rvalid,
   input  logic [PA_W-1:0]   mem_rdata
);
   localparam int PN_W  = VA_W - OFS_W;
   localparam int FN_W  = PA_W - OFS_W;
   localparam int BIT_R = OFS_W - 2;

   if (OFS_W < 5) begin : g_bad_ofs
      $error("offset field too narrow to hold the descriptor flags");
   end
   if (PA_W < VA_W) begin : g_bad_pa
      $error("physical address narrower than virtual address");
   end
   if (PA_W <= PN_W + ENT_SH) begin : g_bad_idx
      $error("table index does not fit the physical address");
   end

   st_e               st_q;
   logic [PA_W-1:0]   base_q;
   logic [PN_W:0]     len_q;
   logic              pgen_q;
   logic [VA_W-1:0]   va_q;
   logic              wr_q;
   logic [PA_W-1:0]   ent_addr_q;
   logic [PA_W-1:0]   pte_new_q;
   logic [PA_W-1:0]   paddr_q;
   flt_e              flt_q;

   logic              accept;
   logic [PA_W-1:0]   ent_addr;
   logic              beyond;
   logic [PA_W-1:0]   pass_pa;
   flt_e              ev_fault;
   logic [FN_W-1:0]   ev_frame;
   logic [PA_W-1:0]   ev_pte;
   logic              ev_wb;

   assign accept = (st_q == ST_IDLE) && req_valid;

   // pass-through width variant
   if (PA_W == VA_W) begin : g_pass_eq
      assign pass_pa = req_vaddr;
   end else begin : g_pass_ext
      assign pass_pa = {{(PA_W-VA_W){1'b0}}, req_vaddr};
   end

   pt_index_gen #(
      .PA_W   (PA_W),
      .PN_W   (PN_W),
      .ENT_SH (ENT_SH)
   ) u_index (
      .clk      (clk),
      .rst_n    (rst_n),
      .page_in  (req_vaddr[VA_W-1:OFS_W]),
      .tbl_base (base_q),
      .tbl_len  (len_q),
      .ent_addr (ent_addr),
      .beyond   (beyond)
   );

   pt_entry_eval #(
      .PA_W  (PA_W),
      .OFS_W (OFS_W)
   ) u_eval (
      .clk      (clk),
      .rst_n    (rst_n),
      .chk_en   ((st_q == ST_WAIT) && mem_rvalid),
      .pte_in   (mem_rdata),
      .is_write (wr_q),
      .fault    (ev_fault),
      .frame    (ev_frame),
      .pte_out  (ev_pte),
      .need_wb  (ev_wb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= '0;
         pgen_q <= 1'b0;
      end else if (cfg_load) begin
         base_q <= cfg_base;
         len_q  <= cfg_len;
         pgen_q <= cfg_page_en;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         va_q       <= '0;
         wr_q       <= 1'b0;
         ent_addr_q <= '0;
         pte_new_q  <= '0;
         paddr_q    <= '0;
         flt_q      <= FLT_NONE;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  va_q <= req_vaddr;
                  wr_q <= req_write;
                  if (!pgen_q) begin
                     paddr_q <= pass_pa;
                     flt_q   <= FLT_NONE;
                     st_q    <= ST_RESP;
                  end else if (beyond) begin
                     paddr_q <= '0;
                     flt_q   <= FLT_RANGE;
                     st_q    <= ST_RESP;
                  end else begin
                     ent_addr_q <= ent_addr;
                     st_q       <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (mem_rvalid) begin
                  flt_q <= ev_fault;
                  if (ev_fault != FLT_NONE) begin
                     paddr_q <= '0;
                     st_q    <= ST_RESP;
                  end else begin
                     paddr_q   <= {ev_frame, va_q[OFS_W-1:0]};
                     pte_new_q <= ev_pte;
                     st_q      <= ev_wb ? ST_WBACK : ST_RESP;
                  end
               end
            end
            ST_WBACK: st_q <= ST_RESP;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == ST_IDLE);
   assign rsp_valid = (st_q == ST_RESP);
   assign rsp_paddr = paddr_q;
   assign rsp_fault = flt_q;
   assign mem_req   = (st_q == ST_FETCH) || (st_q == ST_WBACK);
   assign mem_we    = (st_q == ST_WBACK);
   assign mem_addr  = ent_addr_q;
   assign mem_wdata = pte_new_q;

   // R4: out-of-table page faults on the next cycle
   assert_range_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept && pgen_q && beyond |=> rsp_valid && (rsp_fault == FLT_RANGE));

   // R5: pass-through answers on the next cycle with the raw address
   assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !pgen_q |=> rsp_valid && (rsp_fault == FLT_NONE) &&
                            (rsp_paddr[VA_W-1:0] == $past(req_vaddr)));

   // R8: faults carry no address
   assert_fault_zero_pa_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_fault != FLT_NONE) |-> rsp_paddr == '0);

   // R1: offset bits are preserved on success
   assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_fault == FLT_NONE) |-> rsp_paddr[OFS_W-1:0] == va_q[OFS_W-1:0]);

   // R10: response is a single pulse; idle, memory and response phases exclusive
   assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_phase_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_ready, rsp_valid, mem_req}));

   // R9: every write-back marks the descriptor accessed
   assert_wb_accessed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[BIT_R]);

endmodule

// File: tb/tb_pt_xlate.sv
module tb_pt_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [11:0] cfg_len = '0;
   logic        cfg_page_en = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   logic [31:0] mem_m [logic [31:0]];
   int          rd_cnt = 0;
   int          wr_cnt = 0;
   logic [31:0] last_rd_addr = '0;
   bit          pend = 0;
   logic [31:0] pend_addr = '0;
   int          pend_cnt = 0;

   logic [31:0] m_base = '0;
   logic [11:0] m_len = '0;
   bit          m_pgen = 0;

   always #5 clk = ~clk;

   pt_xlate dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
      .cfg_len(cfg_len), .cfg_page_en(cfg_page_en), .req_valid(req_valid),
      .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   // memory model: reads return after a random delay, writes land at once
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req && mem_we) begin
         mem_m[mem_addr] = mem_wdata;
         wr_cnt = wr_cnt + 1;
      end
      if (mem_req && !mem_we) begin
         pend = 1;
         pend_addr = mem_addr;
         pend_cnt = $urandom % 4;
         rd_cnt = rd_cnt + 1;
         last_rd_addr = mem_addr;
      end else if (pend) begin
         if (pend_cnt == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem_m.exists(pend_addr) ? mem_m[pend_addr] : 32'h0;
            pend = 0;
         end else begin
            pend_cnt = pend_cnt - 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [31:0] b, input logic [11:0] l, input bit pe);
      @(negedge clk);
      cfg_load = 1'b1; cfg_base = b; cfg_len = l; cfg_page_en = pe;
      @(negedge clk);
      cfg_load = 1'b0;
      m_base = b; m_len = l; m_pgen = pe;
   endtask

   task automatic set_pte(input int page, input logic [31:0] v);
      mem_m[m_base + 32'(page) * 4] = v;
   endtask

   function automatic void expect_xl(input logic [23:0] va, input bit wr, input logic [31:0] pte,
                                     output logic [31:0] pa, output logic [1:0] flt,
                                     output logic [31:0] npte, output int erd, output int ewr);
      logic [10:0] pg = va[23:13];
      pa = 0; flt = 0; npte = pte; erd = 0; ewr = 0;
      if (!m_pgen) begin
         pa = {8'h0, va};
      end else if ({1'b0, pg} >= m_len) begin
         flt = 2'd1;
      end else begin
         erd = 1;
         if (!pte[9]) flt = 2'd2;
         else if (wr && !pte[10]) flt = 2'd3;
         else begin
            npte = pte | 32'h800 | (wr ? 32'h1000 : 32'h0);
            pa = {pte[31:13], va[12:0]};
            ewr = (npte != pte) ? 1 : 0;
         end
      end
   endfunction

   task automatic do_txn(input logic [23:0] va, input bit wr);
      logic [31:0] eaddr, pte, epa, enpte, apa;
      logic [1:0]  eflt, aflt;
      int erd, ewr, rd0, wr0, t;
      bit busy_ready;
      string tag;
      eaddr = m_base + 32'(va[23:13]) * 4;
      pte = mem_m.exists(eaddr) ? mem_m[eaddr] : 32'h0;
      expect_xl(va, wr, pte, epa, eflt, enpte, erd, ewr);
      rd0 = rd_cnt; wr0 = wr_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      t = 0; busy_ready = 0;
      while (!rsp_valid && t < 100) begin
         if (req_ready) busy_ready = 1;
         @(negedge clk);
         t++;
      end
      if (t >= 100) begin
         chk(0, "watchdog: no response", 32'(t), 32'd100);
         return;
      end
      apa = rsp_paddr; aflt = rsp_fault;
      chk(!busy_ready, "R10 ready low while busy", 32'(busy_ready), 32'd0);
      case (eflt)
         2'd1: tag = "R4 range fault";
         2'd2: tag = "R6 absent fault";
         2'd3: tag = "R7 write-protect fault";
         default: tag = m_pgen ? "R1 R3 translated" : "R5 pass-through";
      endcase
      chk(aflt == eflt, {tag, " code"}, 32'(aflt), 32'(eflt));
      chk(apa == epa, (eflt != 0) ? "R8 fault address zero" : {tag, " address"}, apa, epa);
      chk(rd_cnt - rd0 == erd, "R2 R4 R5 read count", 32'(rd_cnt - rd0), 32'(erd));
      if (erd == 1)
         chk(last_rd_addr == eaddr, "R2 descriptor address", last_rd_addr, eaddr);
      chk(wr_cnt - wr0 == ewr, "R9 write-back count", 32'(wr_cnt - wr0), 32'(ewr));
      if (erd == 1)
         chk(mem_m[eaddr] == enpte, "R9 descriptor after access", mem_m[eaddr], enpte);
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R10 single-cycle response",
          {30'd0, rsp_valid, req_ready}, 32'd1);
   endtask

   function automatic logic [31:0] mk_pte(input logic [18:0] fr, input bit d, input bit r,
                                          input bit w, input bit v, input logic [8:0] spare);
      return {fr, d, r, w, v, spare};
   endfunction

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req, "R10 reset state",
          {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req, "R10 idle after reset",
          {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);

      // R5 pass-through, translation disabled
      set_cfg(32'h0004_0000, 12'd16, 0);
      do_txn(24'hFFFFFF, 1);
      do_txn(24'h000123, 0);

      // R11 enable takes effect on next request
      set_cfg(32'h0004_0000, 12'd16, 1);
      set_pte(3, mk_pte(19'h5A5A5, 0, 0, 1, 1, 9'h1AB));
      do_txn({11'd3, 13'h1FFF}, 0);                 // R9 accessed only
      do_txn({11'd3, 13'h0000}, 1);                 // R9 accessed+modified
      do_txn({11'd3, 13'h0042}, 1);                 // R9 no write-back needed
      set_pte(4, mk_pte(19'h00001, 0, 1, 0, 1, 9'h0));
      do_txn({11'd4, 13'h0010}, 0);                 // R9 accessed already set
      do_txn({11'd4, 13'h0010}, 1);                 // R7
      set_pte(5, mk_pte(19'h7FFFF, 1, 1, 1, 0, 9'h1FF));
      do_txn({11'd5, 13'h0001}, 0);                 // R6
      set_pte(15, mk_pte(19'h12345, 0, 0, 1, 1, 9'h0));
      do_txn({11'd15, 13'h0ABC}, 0);                // R4 last page inside
      do_txn({11'd16, 13'h0ABC}, 0);                // R4 first page outside
      set_cfg(32'h0004_0000, 12'd0, 1);
      do_txn({11'd0, 13'h0000}, 0);                 // R4 empty table
      set_cfg(32'h0010_0000, 12'd2048, 1);
      set_pte(2047, mk_pte(19'h40000, 0, 0, 0, 1, 9'h055));
      do_txn({11'd2047, 13'h1234}, 0);              // R4 full table top page
      set_cfg(32'h0010_0000, 12'd2048, 0);
      do_txn({11'd2047, 13'h1234}, 0);              // R11 disable applied

      // random mix
      for (int i = 0; i < 400; i++) begin
         if (($urandom % 16) == 0)
            set_cfg({12'h000, 8'($urandom), 12'h000} | 32'h0010_0000,
                    12'(1 + ($urandom % 40)), ($urandom % 8) != 0);
         begin
            int pg;
            logic [31:0] ea;
            pg = $urandom % (int'(m_len) + 4);
            if (pg > 2047) pg = 2047;
            ea = m_base + 32'(pg) * 4;
            if (!mem_m.exists(ea) || ($urandom % 4) == 0)
               mem_m[ea] = $urandom;
            do_txn({11'(pg), 13'($urandom)}, ($urandom % 2) == 1);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not complete, actual %0d expected 0", 1);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule